// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block produces the 12-bit parallel output word of a data converter. In normal operation it registers the live sample, which arrives in offset binary, and passes it to the output. When a 4-bit test-mode field is nonzero, it replaces the live sample with a generated pattern. The pattern can be one of the following:

- a fixed level
- an alternating word pair
- the output of one of two built-in pseudo-random generators

Every word then goes through the same output stage. That stage first converts the word to the number format selected by a 2-bit field. It then inverts all bits if the invert control is set.

Both pseudo-random generators run freely. Each advances once per valid sample, whichever test mode is selected. Each has its own hold control, which forces it back to its all-ones seed. A receiver can therefore re-synchronise to a known sequence start without disturbing the other generator. The output word is registered once, and its valid flag follows the sample strobe.

Top module: `cvt_pattern_out`

## Requirements
- R1: While `rst_n` is low, `out_word` is 0x000 and `out_vld` is 0.
- R2: `out_vld` equals `smp_vld` from the previous rising edge. `out_word` is loaded only on edges where `smp_vld` is 1 and keeps its value otherwise.
- R3: Test mode 0x0 outputs the live sample. The unused codes 0x8 to 0xF behave the same way.
- R4: Test mode 0x1 gives the offset-binary level 0x800. Test mode 0x2 gives 0xFFF. Test mode 0x3 gives 0x000.
- R5: A single phase bit selects the alternating patterns:
  - The phase bit is 0 after reset and flips on every valid sample, in every mode.
  - In mode 0x4 the word is 0xAAA in phase 0 and 0x555 in phase 1.
  - In mode 0x7 the word is 0xFFF in phase 0 and 0x000 in phase 1.
- R6: Mode 0x6 outputs the short generator, built as follows:
  - It is a 9-bit register that resets to all ones.
  - Each step shifts the register left and inserts bit8 XOR bit4 at bit0. This is the polynomial x^9+x^5+1.
  - The output word is {r[8:0], r[8:6]}.
- R7: Mode 0x5 outputs the long generator, built as follows:
  - It is a 23-bit register that resets to all ones.
  - Each step shifts the register left and inserts bit22 XOR bit17 at bit0. This is the polynomial x^23+x^18+1.
  - The output word is r[22:11].
- R8: Each generator has its own hold input:
  - While the hold input is 1, the generator returns to all ones on the next edge.
  - While it is 0, the generator steps once per valid sample, whichever mode is selected.
  - One generator's hold has no effect on the other generator.
- R9: Every source, live or pattern, is formatted by `fmt_sel`:
  - 00 gives offset binary, unchanged.
  - 01 gives two's complement, which flips the MSB.
  - 10 gives Gray code, computed as x XOR (x>>1).
  - 11 behaves like 00.
- R10: When `inv_en` is 1, all twelve bits are inverted after formatting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | 12 | Live sample, offset binary |
| smp_vld | input | 1 | Sample strobe; also steps generators and phase |
| tmode | input | 4 | Test-mode select |
| fmt_sel | input | 2 | Output number format |
| inv_en | input | 1 | Invert all output bits |
| pn_short_hold | input | 1 | Hold 9-bit generator at its seed |
| pn_long_hold | input | 1 | Hold 23-bit generator at its seed |
| out_word | output | 12 | Formatted output word |
| out_vld | output | 1 | Output valid, one cycle after `smp_vld` |

## Verification
The hardest condition to reach is a long pseudo-random sequence observed deep into its run while the other generator and the phase bit keep stepping in the background. This matters most after a hold has been applied to one generator while a different mode was on the output. The bench runs thousands of random cycles with rare, independent hold pulses and frequent mode switches. The reference model steps every generator on every valid sample, so a mode switch exposes any generator that drifted while it was not selected. Directed runs from the seed cover the first steps of each sequence and the hold-while-selected case.

// File: rtl/cvt_pattern_pkg.sv
package cvt_pattern_pkg;

  localparam int unsigned WORD_W = 12;
  localparam int unsigned MODE_W = 4;

  localparam logic [MODE_W-1:0] TM_LIVE     = 4'h0;
  localparam logic [MODE_W-1:0] TM_MID      = 4'h1;
  localparam logic [MODE_W-1:0] TM_POS_FS   = 4'h2;
  localparam logic [MODE_W-1:0] TM_NEG_FS   = 4'h3;
  localparam logic [MODE_W-1:0] TM_CHECKER  = 4'h4;
  localparam logic [MODE_W-1:0] TM_PN_LONG  = 4'h5;
  localparam logic [MODE_W-1:0] TM_PN_SHORT = 4'h6;
  localparam logic [MODE_W-1:0] TM_TOGGLE   = 4'h7;

  typedef enum logic [1:0] {
    FMT_OFFSET = 2'b00,
    FMT_TWOS   = 2'b01,
    FMT_GRAY   = 2'b10,
    FMT_RSVD   = 2'b11
  } fmt_e;

endpackage

// File: rtl/cvt_prbs_gen.sv
module cvt_prbs_gen #(
  parameter int unsigned LEN    = 9,
  parameter int unsigned TAP    = 5,
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              adv,
  output logic [WORD_W-1:0] word
);

  localparam logic [LEN-1:0] SEED = '1;

  logic [LEN-1:0] st_q;
  logic [LEN-1:0] st_d;
  logic           st_en;
  logic           fb_bit;

  assign fb_bit = st_q[LEN-1] ^ st_q[TAP-1];
  assign st_en  = hold | adv;

  always_comb begin
    st_d = st_q;
    if (hold) begin
      st_d = SEED;
    end else if (adv) begin
      st_d = {st_q[LEN-2:0], fb_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEED;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  generate
    if (LEN >= WORD_W) begin : g_wide
      assign word = st_q[LEN-1 -: WORD_W];
    end else begin : g_narrow
      always_comb begin
        for (int i = 0; i < WORD_W; i++) begin
          word[WORD_W-1-i] = st_q[LEN-1-(i % LEN)];
        end
      end
    end
  endgenerate

  // R8
  pn_hold_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (st_q == SEED));

  // R8
  pn_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !adv) |=> $stable(st_q));

  // R6
  pn_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);

  // R7
  pn_step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !hold) |=> (st_q != $past(st_q)));

endmodule

// File: rtl/cvt_pattern_mux.sv
module cvt_pattern_mux
  import cvt_pattern_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [MODE_W-1:0] tmode,
  input  logic [W-1:0]      live,
  input  logic [W-1:0]      pn_short_word,
  input  logic [W-1:0]      pn_long_word,
  output logic [W-1:0]      pat
);

  localparam logic [W-1:0] LVL_MID  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] LVL_POS  = '1;
  localparam logic [W-1:0] LVL_NEG  = '0;

  function automatic logic [W-1:0] alt_word(input logic start_one);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      r[W-1-i] = start_one ^ i[0];
    end
    return r;
  endfunction

  localparam logic [W-1:0] CHK_A = alt_word(1'b1);
  localparam logic [W-1:0] CHK_B = alt_word(1'b0);

  logic ph_q;
  logic ph_d;

  assign ph_d = ~ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 1'b0;
    end else if (adv) begin
      ph_q <= ph_d;
    end
  end

  always_comb begin
    unique case (tmode)
      TM_MID:      pat = LVL_MID;
      TM_POS_FS:   pat = LVL_POS;
      TM_NEG_FS:   pat = LVL_NEG;
      TM_CHECKER:  pat = ph_q ? CHK_B : CHK_A;
      TM_PN_LONG:  pat = pn_long_word;
      TM_PN_SHORT: pat = pn_short_word;
      TM_TOGGLE:   pat = ph_q ? LVL_NEG : LVL_POS;
      default:     pat = live;
    endcase
  end

  // R5
  alt_phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ph_q != $past(ph_q)));

  // R5
  alt_phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ph_q));

endmodule

// File: rtl/cvt_word_format.sv
module cvt_word_format
  import cvt_pattern_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic [1:0]   fmt_sel,
  input  logic         inv_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] coded;

  always_comb begin
    unique case (fmt_e'(fmt_sel))
      FMT_TWOS: coded = din ^ MSB_MASK;
      FMT_GRAY: coded = din ^ (din >> 1);
      default:  coded = din;
    endcase
  end

  assign dout = inv_en ? ~coded : coded;

endmodule

// File: rtl/cvt_pattern_out.sv
module cvt_pattern_out
  import cvt_pattern_pkg::*;
#(
  parameter int unsigned W         = WORD_W,
  parameter int unsigned PN_S_LEN  = 9,
  parameter int unsigned PN_S_TAP  = 5,
  parameter int unsigned PN_L_LEN  = 23,
  parameter int unsigned PN_L_TAP  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      smp_data,
  input  logic              smp_vld,
  input  logic [MODE_W-1:0] tmode,
  input  logic [1:0]        fmt_sel,
  input  logic              inv_en,
  input  logic              pn_short_hold,
  input  logic              pn_long_hold,
  output logic [W-1:0]      out_word,
  output logic              out_vld
);

  logic [W-1:0] pn_s_word;
  logic [W-1:0] pn_l_word;
  logic [W-1:0] pat_word;
  logic [W-1:0] fmt_word;
  logic [W-1:0] word_q;
  logic [W-1:0] word_d;
  logic         vld_q;

  cvt_prbs_gen #(.LEN(PN_S_LEN), .TAP(PN_S_TAP), .WORD_W(W)) i_pn_short (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (pn_short_hold),
    .adv   (smp_vld),
    .word  (pn_s_word)
  );

  cvt_prbs_gen #(.LEN(PN_L_LEN), .TAP(PN_L_TAP), .WORD_W(W)) i_pn_long (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (pn_long_hold),
    .adv   (smp_vld),
    .word  (pn_l_word)
  );

  cvt_pattern_mux #(.W(W)) i_mux (
    .clk           (clk),
    .rst_n         (rst_n),
    .adv           (smp_vld),
    .tmode         (tmode),
    .live          (smp_data),
    .pn_short_word (pn_s_word),
    .pn_long_word  (pn_l_word),
    .pat           (pat_word)
  );

  cvt_word_format #(.W(W)) i_fmt (
    .fmt_sel (fmt_sel),
    .inv_en  (inv_en),
    .din     (pat_word),
    .dout    (fmt_word)
  );

  assign word_d = fmt_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (smp_vld) begin
      word_q <= word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= smp_vld;
    end
  end

  assign out_word = word_q;
  assign out_vld  = vld_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (out_word == '0 && !out_vld));

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> out_vld);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> (!out_vld && $stable(out_word)));

  // R3
  live_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && tmode == TM_LIVE && fmt_sel == 2'b00 && !inv_en)
      |=> (out_word == $past(smp_data)));

endmodule

// File: tb/test_cvt_pattern_out.sv
module test_cvt_pattern_out;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] smp_data;
  logic        smp_vld;
  logic [3:0]  tmode;
  logic [1:0]  fmt_sel;
  logic        inv_en;
  logic        pn_short_hold;
  logic        pn_long_hold;
  logic [11:0] out_word;
  logic        out_vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [8:0]  m_pns;
  logic [22:0] m_pnl;
  logic        m_ph;
  logic [11:0] exp_w;
  logic        exp_v;
  bit          pending;
  string       pend_tag;

  always #10 clk = ~clk;

  cvt_pattern_out i_cvt_pattern_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .smp_data      (smp_data),
    .smp_vld       (smp_vld),
    .tmode         (tmode),
    .fmt_sel       (fmt_sel),
    .inv_en        (inv_en),
    .pn_short_hold (pn_short_hold),
    .pn_long_hold  (pn_long_hold),
    .out_word      (out_word),
    .out_vld       (out_vld)
  );

  function automatic logic [11:0] ref_pattern(input logic [3:0] tm, input logic [11:0] live,
                                              input logic ph, input logic [8:0] s,
                                              input logic [22:0] l);
    case (tm)
      4'h1: return 12'h800;
      4'h2: return 12'hFFF;
      4'h3: return 12'h000;
      4'h4: return ph ? 12'h555 : 12'hAAA;
      4'h5: return l[22:11];
      4'h6: return {s, s[8:6]};
      4'h7: return ph ? 12'h000 : 12'hFFF;
      default: return live;
    endcase
  endfunction

  function automatic logic [11:0] ref_format(input logic [11:0] x, input logic [1:0] f,
                                             input logic inv);
    logic [11:0] y;
    case (f)
      2'b01:   y = x ^ 12'h800;
      2'b10:   y = x ^ (x >> 1);
      default: y = x;
    endcase
    return inv ? ~y : y;
  endfunction

  function automatic string ref_tag(input logic [3:0] tm, input logic [1:0] f, input logic inv);
    if (inv) return "R10";
    if (f != 2'b00) return "R9";
    case (tm)
      4'h1, 4'h2, 4'h3: return "R4";
      4'h4, 4'h7:       return "R5";
      4'h6:             return "R6";
      4'h5:             return "R7";
      default:          return "R3";
    endcase
  endfunction

  task automatic check_out();
    if (!pending) return;
    checks++;
    if (out_vld !== exp_v) begin
      errors++;
      $display("FAIL R2 out_vld actual %0b expected %0b", out_vld, exp_v);
    end
    checks++;
    if (out_word !== exp_w) begin
      errors++;
      $display("FAIL %s out_word actual %03h expected %03h", pend_tag, out_word, exp_w);
    end
  endtask

  task automatic step(input logic v, input logic [11:0] d, input logic [3:0] tm,
                      input logic [1:0] f, input logic inv, input logic hs,
                      input logic hl, input string tag);
    @(negedge clk);
    check_out();
    smp_vld = v; smp_data = d; tmode = tm; fmt_sel = f; inv_en = inv;
    pn_short_hold = hs; pn_long_hold = hl;
    if (v) exp_w = ref_format(ref_pattern(tm, d, m_ph, m_pns, m_pnl), f, inv);
    exp_v = v;
    pend_tag = (tag != "") ? tag : (v ? ref_tag(tm, f, inv) : "R2");
    pending = 1'b1;
    if (v) m_ph = ~m_ph;
    if (hs) m_pns = '1;
    else if (v) m_pns = {m_pns[7:0], m_pns[8] ^ m_pns[4]};
    if (hl) m_pnl = '1;
    else if (v) m_pnl = {m_pnl[21:0], m_pnl[22] ^ m_pnl[17]};
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual still running expected finished");
    finish_run();
  end

  initial begin
    int sd;
    sd = $urandom(32'h5EED);
    rst_n = 1'b0; smp_vld = 1'b0; smp_data = '0; tmode = '0; fmt_sel = '0;
    inv_en = 1'b0; pn_short_hold = 1'b0; pn_long_hold = 1'b0;
    m_pns = '1; m_pnl = '1; m_ph = 1'b0; exp_w = '0; exp_v = 1'b0; pending = 1'b0;
    pend_tag = "";
    repeat (3) @(negedge clk);
    checks++;
    if (out_word !== 12'h000 || out_vld !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual %03h/%0b expected 000/0", out_word, out_vld);
    end
    rst_n = 1'b1;

    // R3 live and unused codes
    step(1, 12'h123, 4'h0, 2'b00, 0, 0, 0, "R3");
    step(1, 12'hFED, 4'h0, 2'b00, 0, 0, 0, "R3");
    for (int c = 8; c < 16; c++) step(1, 12'(c * 291), 4'(c), 2'b00, 0, 0, 0, "R3");
    // R4 levels
    step(1, 12'h0F0, 4'h1, 2'b00, 0, 0, 0, "R4");
    step(1, 12'h0F0, 4'h2, 2'b00, 0, 0, 0, "R4");
    step(1, 12'h0F0, 4'h3, 2'b00, 0, 0, 0, "R4");
    // R2 gaps hold the word
    step(0, 12'h777, 4'h0, 2'b00, 0, 0, 0, "R2");
    step(0, 12'h777, 4'h2, 2'b10, 1, 0, 0, "R2");
    // R5 alternating patterns
    for (int i = 0; i < 4; i++) step(1, 12'h000, 4'h4, 2'b00, 0, 0, 0, "R5");
    for (int i = 0; i < 4; i++) step(1, 12'h000, 4'h7, 2'b00, 0, 0, 0, "R5");
    // R8 reseed both, then R6 / R7 sequences from seed
    step(0, 12'h000, 4'h0, 2'b00, 0, 1, 1, "R8");
    for (int i = 0; i < 20; i++) step(1, 12'h000, 4'h6, 2'b00, 0, 0, 0, "R6");
    for (int i = 0; i < 30; i++) step(1, 12'h000, 4'h5, 2'b00, 0, 0, 0, "R7");
    // R8 hold while selected, other generator unaffected
    step(1, 12'h000, 4'h6, 2'b00, 0, 1, 0, "R8");
    step(1, 12'h000, 4'h6, 2'b00, 0, 1, 0, "R8");
    step(1, 12'h000, 4'h5, 2'b00, 0, 0, 0, "R8");
    step(1, 12'h000, 4'h6, 2'b00, 0, 0, 0, "R8");
    // R9 formats incl. reserved, R10 inversion
    for (int f = 0; f < 4; f++) step(1, 12'h9C3, 4'h0, 2'(f), 0, 0, 0, "R9");
    for (int f = 0; f < 4; f++) step(1, 12'h000, 4'h1, 2'(f), 1, 0, 0, "R10");

    // random mix
    for (int i = 0; i < 6000; i++) begin
      logic [3:0] tm;
      tm = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 0) tm = 4'($urandom_range(5, 6));
      step(($urandom_range(0, 3) != 0), 12'($urandom), tm, 2'($urandom),
           1'($urandom), ($urandom_range(0, 40) == 0), ($urandom_range(0, 60) == 0), "");
    end
    @(negedge clk);
    check_out();
    finish_run();
  end

endmodule